// File: doc/BRIEF.md
# Table-Steered Nonlinear Successive-Approximation Controller

This block runs the digital side of a nonlinear analog-to-digital converter without a successive-approximation register. A small writable table steers the search. Each word holds three fields: a pointer to the next search node, a trial code to send to an external DAC, and a final nonlinear code. The block clears its address register when a conversion starts. In each step it presents the trial code of the current address to the DAC and waits a programmable number of settling cycles. It then samples the external comparator and jumps to a new address. That address is built from the stored pointer in the upper bits and the comparator bit in the least significant bit.

After `ADDR_W` steps the address register itself holds the compressed code, and the final-code field at that address holds the nonlinear code. Loading the table with new contents changes the transfer characteristic, for example to switch between companding laws. The final-code field can be removed by a parameter when only the compressed code is needed. The DAC and comparator are outside the block.

Top module: `nlsar_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy`, `done`, `dac_code`, `comp_code` and `nl_code` are all zero.
- R2: A `start` sampled while idle begins a conversion at table address 0. While busy, `dac_code` equals the trial field of the current address. While idle it is zero. With the example table (n=4, m=5), the first trial is 24 and the second trial is 16 or 28.
- R3: Each step lasts `SETTLE_CYC` settle cycles followed by one compare cycle. At the compare edge the address becomes {pointer field, `cmp_in`}, where `cmp_in`=1 means the input is at or above the trial level.
- R4: `done` is a one-cycle pulse that rises `ADDR_W*(SETTLE_CYC+1)+1` clock edges after the edge that accepted `start`. `busy` is low while `done` is high.
- R5: At `done`, `comp_code` is the final address and `nl_code` is the final field stored at that address. Both hold their values until the next `done`.
- R6: `start` is ignored while a conversion is in progress. It neither restarts nor extends the conversion.
- R7: When `wr_en` is high while idle, the word at `wr_addr` is written with pointer `wr_ptr` (ADDR_W-1 bits), trial `wr_trial` and final `wr_final` (CODE_W bits each). A reload changes the characteristic of later conversions.
- R8: `wr_en` is refused while busy, and the table keeps its contents.
- R9: With `KEEP_FINAL`=0 no final field is stored and `nl_code` is always zero, while `comp_code` behaves as with the field present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion (sampled only when idle) |
| cmp_in | input | 1 | Comparator result, 1 = input at or above the DAC level |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | ADDR_W | Table word to write |
| wr_ptr | input | ADDR_W-1 | Next-node pointer field |
| wr_trial | input | CODE_W | Trial code field |
| wr_final | input | CODE_W | Final nonlinear code field |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| dac_code | output | CODE_W | Code presented to the external DAC |
| comp_code | output | ADDR_W | Compressed result code |
| nl_code | output | CODE_W | Nonlinear result code |

## Verification
The hardest situations to reach are the collisions between a running search and the two other inputs: a second `start`, or a table write that targets the exact final word the running search is about to read. The bench models the comparator from `dac_code` against a held input level. In the middle of a conversion it injects either a start pulse or a write that overwrites the final field of the expected result address. It then checks that the latency, the compressed code and the nonlinear code stay unchanged, both in that conversion and in the next. Sweeping every input level under two different table loads covers every search path and every final address.

// File: rtl/nlsar_pkg.sv
package nlsar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_CMP    = 2'd2,
        ST_FINISH = 2'd3
    } nlsar_state_e;

    // Width of a counter that must reach value lim-1 (at least one bit).
    function automatic int cnt_width(input int lim);
        return (lim > 1) ? $clog2(lim) : 1;
    endfunction

endpackage

// File: rtl/nlsar_table.sv
module nlsar_table
    import nlsar_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int CODE_W     = 5,
    parameter bit KEEP_FINAL = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [ADDR_W-2:0] wptr,
    input  logic [CODE_W-1:0] wtrial,
    input  logic [CODE_W-1:0] wfinal,
    input  logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W-2:0] rptr,
    output logic [CODE_W-1:0] rtrial,
    output logic [CODE_W-1:0] rfinal,
    input  logic [ADDR_W-1:0] faddr
);
    localparam int WORDS = 1 << ADDR_W;

    logic [ADDR_W-2:0] ptr_mem   [WORDS];
    logic [CODE_W-1:0] trial_mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) begin
                ptr_mem[i]   <= '0;
                trial_mem[i] <= '0;
            end
        end else if (we) begin
            ptr_mem[waddr]   <= wptr;
            trial_mem[waddr] <= wtrial;
        end
    end

    assign rptr   = ptr_mem[raddr];
    assign rtrial = trial_mem[raddr];

    generate
        if (KEEP_FINAL) begin : g_final
            logic [CODE_W-1:0] final_mem [WORDS];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < WORDS; i++) final_mem[i] <= '0;
                end else if (we) begin
                    final_mem[waddr] <= wfinal;
                end
            end
            assign rfinal = final_mem[faddr];
        end else begin : g_nofinal
            logic unused_final;
            assign unused_final = ^{wfinal, faddr};
            assign rfinal = '0;
        end
    endgenerate

endmodule

// File: rtl/nlsar_seq.sv
module nlsar_seq
    import nlsar_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int SETTLE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cmp_in,
    input  logic [ADDR_W-2:0] ptr_in,
    output logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              finish
);
    localparam int SW  = cnt_width(SETTLE_CYC);
    localparam int STW = cnt_width(ADDR_W);
    localparam logic [SW-1:0]  SETTLE_LAST = SW'(SETTLE_CYC - 1);
    localparam logic [STW-1:0] STEP_LAST   = STW'(ADDR_W - 1);

    nlsar_state_e      state;
    logic [SW-1:0]     settle_cnt;
    logic [STW-1:0]    step_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            addr       <= '0;
            settle_cnt <= '0;
            step_cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state      <= ST_SETTLE;
                        addr       <= '0;
                        settle_cnt <= '0;
                        step_cnt   <= '0;
                    end
                end
                ST_SETTLE: begin
                    if (settle_cnt == SETTLE_LAST) begin
                        settle_cnt <= '0;
                        state      <= ST_CMP;
                    end else begin
                        settle_cnt <= settle_cnt + 1'b1;
                    end
                end
                ST_CMP: begin
                    addr <= {ptr_in, cmp_in};
                    if (step_cnt == STEP_LAST) begin
                        state <= ST_FINISH;
                    end else begin
                        step_cnt <= step_cnt + 1'b1;
                        state    <= ST_SETTLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (state != ST_IDLE);
    assign finish = (state == ST_FINISH);

endmodule

// File: rtl/nlsar_ctrl.sv
module nlsar_ctrl
    import nlsar_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int CODE_W     = 5,
    parameter int SETTLE_CYC = 2,
    parameter bit KEEP_FINAL = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cmp_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-2:0] wr_ptr,
    input  logic [CODE_W-1:0] wr_trial,
    input  logic [CODE_W-1:0] wr_final,
    output logic              busy,
    output logic              done,
    output logic [CODE_W-1:0] dac_code,
    output logic [ADDR_W-1:0] comp_code,
    output logic [CODE_W-1:0] nl_code
);
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-2:0] cur_ptr;
    logic [CODE_W-1:0] cur_trial;
    logic [CODE_W-1:0] fin_code;
    logic              seq_busy;
    logic              seq_finish;
    logic              wr_ok;

    assign wr_ok = wr_en && !seq_busy;

    nlsar_table #(
        .ADDR_W(ADDR_W), .CODE_W(CODE_W), .KEEP_FINAL(KEEP_FINAL)
    ) u_table (
        .clk(clk), .rst(rst), .we(wr_ok), .waddr(wr_addr),
        .wptr(wr_ptr), .wtrial(wr_trial), .wfinal(wr_final),
        .raddr(cur_addr), .rptr(cur_ptr), .rtrial(cur_trial),
        .rfinal(fin_code), .faddr(cur_addr)
    );

    nlsar_seq #(
        .ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE_CYC)
    ) u_seq (
        .clk(clk), .rst(rst), .start(start), .cmp_in(cmp_in),
        .ptr_in(cur_ptr), .addr(cur_addr), .busy(seq_busy),
        .finish(seq_finish)
    );

    logic [ADDR_W-1:0] comp_q;
    logic [CODE_W-1:0] nl_q;
    logic              done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            comp_q <= '0;
            nl_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= seq_finish;
            if (seq_finish) begin
                comp_q <= cur_addr;
                nl_q   <= fin_code;
            end
        end
    end

    assign busy      = seq_busy;
    assign done      = done_q;
    assign dac_code  = seq_busy ? cur_trial : '0;
    assign comp_code = comp_q;
    assign nl_code   = nl_q;

endmodule

// File: rtl/nlsar_ctrl_chk.sv
module nlsar_ctrl_chk #(
    parameter int ADDR_W     = 4,
    parameter int CODE_W     = 5,
    parameter bit KEEP_FINAL = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [CODE_W-1:0] dac_code,
    input logic [ADDR_W-1:0] comp_code,
    input logic [CODE_W-1:0] nl_code
);
    a_r2_dac_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (dac_code == '0));

    a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r4_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r6_busy_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    a_r5_comp_held: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(comp_code));

    a_r5_nl_held: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(nl_code));

    generate
        if (!KEEP_FINAL) begin : g_nf
            a_r9_nl_zero: assert property (@(posedge clk) disable iff (rst)
                nl_code == '0);
        end
    endgenerate

endmodule

bind nlsar_ctrl nlsar_ctrl_chk #(
    .ADDR_W(ADDR_W), .CODE_W(CODE_W), .KEEP_FINAL(KEEP_FINAL)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .dac_code(dac_code), .comp_code(comp_code), .nl_code(nl_code)
);

// File: tb/nlsar_ctrl_tb.sv
module nlsar_ctrl_tb;
    localparam int N = 4;
    localparam int M = 5;
    localparam int S = 2;
    localparam int WORDS = 1 << N;
    localparam int LAT = N * (S + 1) + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic wr_en = 1'b0;
    logic [N-1:0] wr_addr = '0;
    logic [N-2:0] wr_ptr = '0;
    logic [M-1:0] wr_trial = '0;
    logic [M-1:0] wr_final = '0;
    int vin = 0;

    logic busy, done, busy_nf, done_nf;
    logic [M-1:0] dac_code, nl_code, dac_nf, nl_nf;
    logic [N-1:0] comp_code, comp_nf;
    logic cmp_a, cmp_b;

    assign cmp_a = (vin >= int'(dac_code));
    assign cmp_b = (vin >= int'(dac_nf));

    always #2 clk = ~clk;

    nlsar_ctrl #(.ADDR_W(N), .CODE_W(M), .SETTLE_CYC(S), .KEEP_FINAL(1'b1)) u_dut (
        .clk(clk), .rst(rst), .start(start), .cmp_in(cmp_a), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_ptr(wr_ptr), .wr_trial(wr_trial), .wr_final(wr_final),
        .busy(busy), .done(done), .dac_code(dac_code), .comp_code(comp_code),
        .nl_code(nl_code)
    );

    nlsar_ctrl #(.ADDR_W(N), .CODE_W(M), .SETTLE_CYC(S), .KEEP_FINAL(1'b0)) u_dut_nf (
        .clk(clk), .rst(rst), .start(start), .cmp_in(cmp_b), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_ptr(wr_ptr), .wr_trial(wr_trial), .wr_final(wr_final),
        .busy(busy_nf), .done(done_nf), .dac_code(dac_nf), .comp_code(comp_nf),
        .nl_code(nl_nf)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Characteristic A: steep low segment, then fine steps; B: odd ramp.
    function automatic int nl_of(input int sel, input int lin);
        if (sel == 0) begin
            if (lin < 6) return 4 * lin;
            else if (lin < 8) return 16 + lin;
            else return 16 + lin;
        end
        return 2 * lin + 1;
    endfunction

    function automatic int expect_lin(input int sel, input int v);
        int best = 0;
        for (int l = 0; l < WORDS; l++) if (nl_of(sel, l) <= v) best = l;
        return best;
    endfunction

    task automatic write_word(input int a, input int p, input int t, input int f);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = N'(a); wr_ptr = (N-1)'(p);
        wr_trial = M'(t); wr_final = M'(f);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic load_table(input int sel);
        int ptr_t [WORDS];
        int trial_t [WORDS];
        for (int i = 0; i < WORDS; i++) begin ptr_t[i] = 0; trial_t[i] = 0; end
        for (int l = 0; l < WORDS; l++) begin
            int a = 0;
            int t = WORDS / 2;
            int w = WORDS / 4;
            for (int st = 0; st < N; st++) begin
                int b;
                ptr_t[a] = t / 2;
                trial_t[a] = nl_of(sel, t);
                b = (l >= t) ? 1 : 0;
                a = (t / 2) * 2 + b;
                t = b ? t + w : t - w;
                w = w / 2;
            end
        end
        for (int i = 0; i < WORDS; i++) write_word(i, ptr_t[i], trial_t[i], nl_of(sel, i));
    endtask

    task automatic convert(input int v, input bit poke_start, input bit poke_wr,
                           input int poke_addr,
                           output int comp, output int nl, output int lat,
                           output int d0, output int d1, output int ncomp,
                           output int nnl, output int done_after);
        vin = v;
        d0 = -1; d1 = -1; lat = -1;
        @(negedge clk);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        d0 = int'(dac_code);
        for (int cnt = 1; cnt < 60; cnt++) begin
            @(posedge clk); #1;
            start = 1'b0;
            wr_en = 1'b0;
            if (cnt == 3) d1 = int'(dac_code);
            if (done) begin
                lat = cnt;
                comp = int'(comp_code); nl = int'(nl_code);
                ncomp = int'(comp_nf); nnl = int'(nl_nf);
                check(!busy, "R4 busy low at done", int'(busy), 0);
                break;
            end
            if (cnt == 5 && poke_start) start = 1'b1;
            if (cnt == 5 && poke_wr) begin
                wr_en = 1'b1; wr_addr = N'(poke_addr); wr_ptr = '0;
                wr_trial = '0; wr_final = 5'd31;
            end
        end
        @(posedge clk); #1;
        done_after = int'(done);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int comp, nl, lat, d0, d1, ncomp, nnl, dn;
        int ex;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(!busy && !done && dac_code == 0 && comp_code == 0 && nl_code == 0,
              "R1 reset outputs", int'({busy, done, dac_code, comp_code, nl_code}), 0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check(!busy && !done && dac_code == 0 && comp_code == 0 && nl_code == 0,
              "R1 after reset", int'({busy, done, dac_code, comp_code, nl_code}), 0);

        load_table(0);
        check(dac_code == 0, "R2 idle dac zero", int'(dac_code), 0);

        // R3 R5 R9: full sweep with characteristic A
        for (int v = 0; v < 32; v++) begin
            convert(v, 1'b0, 1'b0, 0, comp, nl, lat, d0, d1, ncomp, nnl, dn);
            ex = expect_lin(0, v);
            check(comp == ex, "R3 compressed code A", comp, ex);
            check(nl == nl_of(0, ex), "R5 nonlinear code A", nl, nl_of(0, ex));
            check(ncomp == ex, "R9 compressed without final field", ncomp, ex);
            check(nnl == 0, "R9 nonlinear zero without final field", nnl, 0);
            check(lat == LAT, "R4 done latency", lat, LAT);
            check(dn == 0, "R4 done single cycle", dn, 0);
            check(d0 == 24, "R2 first trial", d0, 24);
            check(d1 == ((v >= 24) ? 28 : 16), "R2 second trial", d1, (v >= 24) ? 28 : 16);
        end

        // R5: results held while idle, vin changes
        vin = 3;
        repeat (5) @(posedge clk);
        #1;
        check(comp_code == 4'd15, "R5 compressed held", int'(comp_code), 15);
        check(nl_code == 5'd31, "R5 nonlinear held", int'(nl_code), 31);

        // R6: start while busy ignored
        convert(13, 1'b1, 1'b0, 0, comp, nl, lat, d0, d1, ncomp, nnl, dn);
        check(lat == LAT, "R6 latency with extra start", lat, LAT);
        check(comp == 3 && nl == 12, "R6 result with extra start", comp, 3);
        check(!busy, "R6 no restart", int'(busy), 0);

        // R8: write while busy to the expected final word is refused
        convert(10, 1'b0, 1'b1, 2, comp, nl, lat, d0, d1, ncomp, nnl, dn);
        check(nl == 8, "R8 busy write refused same run", nl, 8);
        convert(10, 1'b0, 1'b0, 0, comp, nl, lat, d0, d1, ncomp, nnl, dn);
        check(comp == 2 && nl == 8, "R8 busy write refused next run", nl, 8);

        // R7: reload with characteristic B
        load_table(1);
        for (int v = 0; v < 32; v++) begin
            convert(v, 1'b0, 1'b0, 0, comp, nl, lat, d0, d1, ncomp, nnl, dn);
            ex = expect_lin(1, v);
            check(comp == ex, "R7 compressed code B", comp, ex);
            check(nl == nl_of(1, ex), "R7 nonlinear code B", nl, nl_of(1, ex));
            check(d0 == 17, "R7 first trial B", d0, 17);
            check(nnl == 0 && ncomp == ex, "R9 no final field B", nnl, 0);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule